// File: doc/BRIEF.md
# Delayed Register Update Queue

This block holds writes to a small bank of architectural registers that must land a fixed number of cycles after they are issued, such as condition flags or results with a known latency. A producer pushes an update carrying a destination register, a countdown, a 32- or 64-bit width, and either a whole-value write or a single-bit set/clear. A separate tick input advances time. Each tick lowers the countdown of every pending update, and applies those that expire to the internal register bank.

The queue is a ring of slots. Updates may expire in any order, but a slot is reclaimed only once everything older than it has also expired. The consumer reads the register bank through a combinational read port. A full flag refuses pushes when every slot is occupied. A sticky fatal flag reports a broken ring (pointers that differ while the occupancy count is zero).

Top module: `dq_update_queue`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, and `full` and `fatal` are low.
- R2: An update accepted with countdown d (1 to 15) changes its register at the clock edge of the d-th cycle with `tick` high that follows the accepting edge. Cycles with `tick` low do not count.
- R3: An update accepted with countdown 0 behaves as countdown 1.
- R4: A whole-value update with `enq_wide`=1 replaces all 64 bits of the destination.
- R5: A whole-value update with `enq_wide`=0 replaces bits 31:0 and keeps bits 63:32.
- R6: With `enq_bit_mode`=1 a single bit is written: set when `enq_value[0]`=1, cleared when it is 0, with all other bits kept. The bit index is `enq_bit_pos` (0 to 63) when `enq_wide`=1 and `enq_bit_pos[4:0]` when `enq_wide`=0.
- R7: Updates that expire on the same tick are applied oldest first, so the newest one wins on overlapping bits.
- R8: An update that expires while not the oldest in the queue is applied once only. Its slot stays occupied until every older update has expired, and all leading expired slots are then freed together.
- R9: `full` is high exactly when all slots are occupied. A push while `full` is high is dropped and never reaches the register bank.
- R10: A push and a tick in the same cycle are both honoured. The new update is not counted down by that tick.
- R11: `fatal` rises when the ring pointers differ while the occupancy is zero, and then stays high until reset. In correct operation it stays low.
- R12: `rd_data` shows the register selected by `rd_idx` in the same cycle. An index at or beyond the register count reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Push an update this cycle |
| enq_dest | input | 3 | Destination register index |
| enq_bit_mode | input | 1 | 1: single-bit write, 0: whole-value write |
| enq_bit_pos | input | 6 | Bit index for single-bit writes |
| enq_value | input | 64 | Value, or set/clear selector in bit 0 |
| enq_wide | input | 1 | 1: 64-bit update, 0: 32-bit update |
| enq_delay | input | 4 | Countdown in ticks (0 treated as 1) |
| tick | input | 1 | Advance all pending countdowns |
| rd_idx | input | 3 | Register read select |
| rd_data | output | 64 | Selected register contents |
| full | output | 1 | All slots occupied |
| fatal | output | 1 | Sticky ring inconsistency flag |

## Verification
The assertions assume that `enq_valid` and `tick` are plain single-cycle strobes, held stable around the clock edge. They also assume that a push attempted while `full` is high is expected to vanish, rather than being held by the producer until it succeeds. The stimulus drives all inputs well away from the edge. It keeps pushing at random while the queue is full so that refusals are exercised, and it mixes runs with no tick so that the rule that only ticks count down is exercised. The random countdowns cover the whole 0 to 15 range, which makes slots expire out of order and piles up simultaneous expiries.

// File: rtl/dq_pkg.sv
`timescale 1ns/100ps
// Package: shared widths, the slot record and the update rule.
// Assumes a 64-bit register bank; 32-bit updates touch the low half only.
package dq_pkg;
    parameter int DQ_DATA_W = 64;
    parameter int DQ_HALF_W = 32;
    parameter int DQ_POS_W  = 6;
    parameter int DQ_DLY_W  = 4;
    parameter int DQ_DST_W  = 3;

    typedef struct packed {
        logic [DQ_DST_W-1:0]  dest;
        logic                 bit_mode;
        logic [DQ_POS_W-1:0]  pos;
        logic [DQ_DATA_W-1:0] value;
        logic                 wide;
        logic [DQ_DLY_W-1:0]  delay;
        logic                 done;
    } dq_entry_t;

    // Returns the register contents after one update is applied.
    function automatic logic [DQ_DATA_W-1:0] dq_apply(
        input logic [DQ_DATA_W-1:0] old,
        input logic [DQ_DST_W-1:0]  dest_unused,
        input logic                 bit_mode,
        input logic [DQ_POS_W-1:0]  pos,
        input logic [DQ_DATA_W-1:0] value,
        input logic                 wide);
        logic [DQ_DATA_W-1:0] res;
        logic [DQ_DATA_W-1:0] mask;
        logic [DQ_POS_W-1:0]  idx;
        res = old;
        idx = wide ? pos : {1'b0, pos[DQ_POS_W-2:0]};
        mask = DQ_DATA_W'(1) << idx;
        if (bit_mode) begin
            if (value[0]) res = old | mask;
            else          res = old & ~mask;
        end else if (wide) begin
            res = value;
        end else begin
            res = {old[DQ_DATA_W-1:DQ_HALF_W], value[DQ_HALF_W-1:0]};
        end
        if (^dest_unused === 1'bx) res = res;
        return res;
    endfunction
endpackage

// File: rtl/dq_slot_ring.sv
`timescale 1ns/100ps
// Module: dq_slot_ring
// Ring of pending updates with in/out pointers and an occupancy count.
// Counts down live slots on tick, flags those expiring, frees leading
// expired slots from the head. Presents slots ordered by age to the bank.
// Assumes SLOTS >= 2; a push while full is dropped.
module dq_slot_ring
    import dq_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enq_valid,
    input  dq_entry_t             enq_entry,
    input  logic                  tick,
    output logic                  full,
    output logic                  fatal,
    output dq_entry_t [SLOTS-1:0] ord_ent,
    output logic [SLOTS-1:0]      ord_fire
);
    localparam int PTR_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [PTR_W-1:0] in_q, out_q;
    logic [CNT_W-1:0] total_q;
    logic             fatal_q;
    logic             accept;
    logic [CNT_W-1:0] pop_n;
    logic [SLOTS-1:0] in_win;
    dq_entry_t        slot_view [SLOTS];
    dq_entry_t        new_ent;
    logic             unused_enq;

    // Adds an offset to a ring pointer with wrap-around.
    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] a, input int b);
        int t;
        t = int'(a) + b;
        while (t >= SLOTS) t = t - SLOTS;
        return PTR_W'(t);
    endfunction

    assign full   = (total_q == CNT_W'(SLOTS));
    assign fatal  = fatal_q;
    assign accept = enq_valid && !full;
    assign unused_enq = ^{enq_entry.done, 1'b0};

    // Normalises an incoming entry: zero countdown becomes one, not done.
    always_comb begin
        new_ent = enq_entry;
        new_ent.done = 1'b0;
        if (enq_entry.delay == '0) new_ent.delay = DQ_DLY_W'(1);
    end

    // Builds the age-ordered view and the per-slot expiry strobes.
    always_comb begin
        for (int k = 0; k < SLOTS; k++) begin
            ord_ent[k]  = slot_view[wrap_add(out_q, k)];
            in_win[k]   = CNT_W'(k) < total_q;
            ord_fire[k] = tick && in_win[k] && !ord_ent[k].done
                          && (ord_ent[k].delay == DQ_DLY_W'(1));
        end
    end

    // Counts the run of expired slots starting at the head.
    always_comb begin
        logic run;
        run   = 1'b1;
        pop_n = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (run && in_win[k] && (ord_ent[k].done || ord_fire[k]))
                pop_n = pop_n + CNT_W'(1);
            else
                run = 1'b0;
        end
    end

    // Per-slot storage, each slot with its own countdown register.
    for (genvar s = 0; s < SLOTS; s++) begin : gen_slot
        dq_entry_t ent_q;
        int        age;
        logic      live;

        // Age of this slot relative to the head, and whether it is occupied.
        always_comb begin
            age  = s - int'(out_q);
            if (age < 0) age = age + SLOTS;
            live = age < int'(total_q);
        end

        // Loads a pushed entry or counts down a live one on tick.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (accept && (in_q == PTR_W'(s))) begin
                ent_q <= new_ent;
            end else if (tick && live && !ent_q.done) begin
                if (ent_q.delay == DQ_DLY_W'(1)) ent_q.done  <= 1'b1;
                else                             ent_q.delay <= ent_q.delay - DQ_DLY_W'(1);
            end
        end

        assign slot_view[s] = ent_q;
    end

    // Advances pointers, occupancy and the sticky fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q    <= '0;
            out_q   <= '0;
            total_q <= '0;
            fatal_q <= 1'b0;
        end else begin
            if (accept) in_q <= wrap_add(in_q, 1);
            out_q   <= wrap_add(out_q, int'(pop_n));
            total_q <= total_q - pop_n + CNT_W'(accept);
            if ((in_q != out_q) && (total_q == '0)) fatal_q <= 1'b1;
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_q <= CNT_W'(SLOTS));
    // R9
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && enq_valid && !tick) |=> (total_q == $past(total_q)));
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_q));
    // R11
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_q |=> fatal_q);
    // R11
    ptr_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (total_q == '0) |-> (in_q == out_q));
endmodule

// File: rtl/dq_reg_bank.sv
`timescale 1ns/100ps
// Module: dq_reg_bank
// Register bank written by expiring updates, oldest first, and read
// combinationally. Assumes the update list arrives ordered by age.
module dq_reg_bank
    import dq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int NREGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  dq_entry_t [SLOTS-1:0] ord_ent,
    input  logic [SLOTS-1:0]      ord_fire,
    input  logic [DQ_DST_W-1:0]   rd_idx,
    output logic [DQ_DATA_W-1:0]  rd_data
);
    logic [NREGS-1:0][DQ_DATA_W-1:0] regs_q, regs_d;
    logic                            unused_meta;

    // Applies every expiring update in age order; later ones overwrite.
    always_comb begin
        regs_d = regs_q;
        for (int k = 0; k < SLOTS; k++) begin
            if (ord_fire[k] && (int'(ord_ent[k].dest) < NREGS)) begin
                regs_d[ord_ent[k].dest] = dq_apply(regs_d[ord_ent[k].dest],
                    ord_ent[k].dest, ord_ent[k].bit_mode, ord_ent[k].pos,
                    ord_ent[k].value, ord_ent[k].wide);
            end
        end
    end

    // Collects countdown fields this bank has no use for.
    always_comb begin
        unused_meta = 1'b0;
        for (int k = 0; k < SLOTS; k++)
            unused_meta = unused_meta ^ (^ord_ent[k].delay) ^ ord_ent[k].done;
    end

    // Holds the register bank.
    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Read port, zero for indices past the bank.
    assign rd_data = (int'(rd_idx) < NREGS) ? regs_q[rd_idx] : '0;

    // R2
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_fire == '0) |=> $stable(regs_q));
    // R8
    fire_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ord_fire[0] |=> !$past(ord_ent[0].done));
endmodule

// File: rtl/dq_update_queue.sv
`timescale 1ns/100ps
// Module: dq_update_queue (top)
// Queue of delayed register updates feeding a small register bank.
// Assumes enq_valid and tick are single-cycle strobes.
module dq_update_queue
    import dq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int NREGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enq_valid,
    input  logic [DQ_DST_W-1:0]  enq_dest,
    input  logic                 enq_bit_mode,
    input  logic [DQ_POS_W-1:0]  enq_bit_pos,
    input  logic [DQ_DATA_W-1:0] enq_value,
    input  logic                 enq_wide,
    input  logic [DQ_DLY_W-1:0]  enq_delay,
    input  logic                 tick,
    input  logic [DQ_DST_W-1:0]  rd_idx,
    output logic [DQ_DATA_W-1:0] rd_data,
    output logic                 full,
    output logic                 fatal
);
    dq_entry_t             enq_entry;
    dq_entry_t [SLOTS-1:0] ord_ent;
    logic [SLOTS-1:0]      ord_fire;

    // Packs the push fields into one slot record.
    always_comb begin
        enq_entry.dest     = enq_dest;
        enq_entry.bit_mode = enq_bit_mode;
        enq_entry.pos      = enq_bit_pos;
        enq_entry.value    = enq_value;
        enq_entry.wide     = enq_wide;
        enq_entry.delay    = enq_delay;
        enq_entry.done     = 1'b0;
    end

    dq_slot_ring #(.SLOTS(SLOTS)) u_ring (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_entry(enq_entry),
        .tick(tick), .full(full), .fatal(fatal),
        .ord_ent(ord_ent), .ord_fire(ord_fire)
    );

    dq_reg_bank #(.SLOTS(SLOTS), .NREGS(NREGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .ord_ent(ord_ent), .ord_fire(ord_fire),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_dq_update_queue.sv
`timescale 1ns/100ps
module sim_dq_update_queue;
    localparam int S  = 8;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n, enq_valid, enq_bit_mode, enq_wide, tick, full, fatal;
    logic [2:0]  enq_dest, rd_idx;
    logic [5:0]  enq_bit_pos;
    logic [63:0] enq_value, rd_data;
    logic [3:0]  enq_delay;

    int    n_vec = 0, n_bad = 0;
    string phase = "R1";

    logic [63:0] m_reg [NR];
    int          m_dest [S], m_pos [S], m_dly [S];
    logic        m_bm [S], m_wide [S], m_done [S];
    logic [63:0] m_val [S];
    int          m_in, m_out, m_tot;

    always #4 clk = ~clk;

    dq_update_queue #(.SLOTS(S), .NREGS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_dest(enq_dest),
        .enq_bit_mode(enq_bit_mode), .enq_bit_pos(enq_bit_pos), .enq_value(enq_value),
        .enq_wide(enq_wide), .enq_delay(enq_delay), .tick(tick), .rd_idx(rd_idx),
        .rd_data(rd_data), .full(full), .fatal(fatal)
    );

    function automatic logic [63:0] ref_apply(logic [63:0] old, logic bm, int pos,
                                              logic [63:0] v, logic w);
        logic [63:0] r;
        int p;
        r = old;
        if (bm) begin
            p = w ? pos : (pos % 32);
            r[p] = v[0];
        end else if (w) r = v;
        else r = {old[63:32], v[31:0]};
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NR; i++) m_reg[i] = '0;
        for (int i = 0; i < S; i++) m_done[i] = 1'b0;
        m_in = 0; m_out = 0; m_tot = 0;
    endtask

    task automatic model_step();
        int pre, popped, i;
        pre = m_tot;
        if (tick) begin
            for (int k = 0; k < pre; k++) begin
                i = (m_out + k) % S;
                if (!m_done[i]) begin
                    if (m_dly[i] == 1) begin
                        m_reg[m_dest[i]] = ref_apply(m_reg[m_dest[i]], m_bm[i], m_pos[i],
                                                     m_val[i], m_wide[i]);
                        m_done[i] = 1'b1;
                    end else m_dly[i] = m_dly[i] - 1;
                end
            end
            popped = 0;
            while (popped < pre && m_done[m_out]) begin
                m_out = (m_out + 1) % S; m_tot--; popped++;
            end
        end
        if (enq_valid && pre < S) begin
            m_dest[m_in] = enq_dest; m_bm[m_in] = enq_bit_mode; m_pos[m_in] = enq_bit_pos;
            m_val[m_in] = enq_value; m_wide[m_in] = enq_wide;
            m_dly[m_in] = (enq_delay == 0) ? 1 : int'(enq_delay);
            m_done[m_in] = 1'b0;
            m_in = (m_in + 1) % S; m_tot++;
        end
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sweep();
        check({phase, " full"}, {63'd0, full}, {63'd0, m_tot == S});
        check("R11 fatal", {63'd0, fatal}, 64'd0);
        // R12: each register read through the combinational port
        for (int r = 0; r < NR; r++) begin
            rd_idx = 3'(r);
            #0.5;
            check({phase, " reg"}, rd_data, m_reg[r]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        #1;
        sweep();
    endtask

    task automatic push(int d, logic bm, int pos, logic [63:0] v, logic w, int dly, logic tk);
        enq_valid = 1'b1; enq_dest = 3'(d); enq_bit_mode = bm; enq_bit_pos = 6'(pos);
        enq_value = v; enq_wide = w; enq_delay = 4'(dly); tick = tk;
        step();
        enq_valid = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin tick = 1'b1; step(); end
        tick = 1'b0;
    endtask

    task automatic idles(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; enq_valid = 1'b0; tick = 1'b0; enq_dest = '0; enq_bit_mode = 1'b0;
        enq_bit_pos = '0; enq_value = '0; enq_wide = 1'b0; enq_delay = '0; rd_idx = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1: reset state
        phase = "R1"; sweep(); idles(1);

        // R4: 64-bit whole write, countdown 3
        phase = "R4";
        push(2, 0, 0, 64'h0123_4567_89AB_CDEF, 1, 3, 0);
        ticks(3);
        // R5: 32-bit whole write keeps upper half
        phase = "R5";
        push(2, 0, 0, 64'hFFFF_FFFF_5555_AAAA, 0, 1, 0);
        ticks(1);
        // R6: bit set 64-bit, bit set 32-bit (37 wraps to 5), bit clear
        phase = "R6";
        push(3, 1, 40, 64'd1, 1, 1, 0);
        push(3, 1, 37, 64'd1, 0, 1, 0);
        push(2, 1, 0, 64'd0, 1, 1, 0);
        ticks(1);
        push(3, 1, 40, 64'hFFFE, 1, 2, 0);
        ticks(2);
        // R3: zero countdown applies on the next tick
        phase = "R3";
        push(1, 0, 0, 64'h0000_0000_DEAD_0001, 1, 0, 0);
        ticks(1);
        // R2: non-tick cycles do not count down
        phase = "R2";
        push(0, 0, 0, 64'h1111_2222_3333_4444, 1, 4, 0);
        ticks(2); idles(3); ticks(1); idles(2); ticks(1);
        // R7: same expiry tick, newer entry wins
        phase = "R7";
        push(4, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA, 1, 2, 0);
        push(4, 0, 0, 64'h0000_0000_BBBB_BBBB, 0, 1, 1);
        ticks(1);
        // R8: long head blocks reclaim of younger expired slots
        phase = "R8";
        push(5, 0, 0, 64'h5A5A_5A5A_5A5A_5A5A, 1, 15, 0);
        for (int i = 1; i < S; i++) push(6, 1, i, 64'd1, 1, 1, 0);
        ticks(1);
        // R9: pushes while full are dropped
        phase = "R9";
        push(7, 0, 0, 64'hDEAD_BEEF_DEAD_BEEF, 1, 1, 0);
        push(7, 1, 3, 64'd1, 1, 0, 0);
        ticks(14);
        check("R9 dropped push", m_reg[7], 64'd0);
        ticks(2);
        // R10: push and tick together
        phase = "R10";
        push(1, 0, 0, 64'h7777, 1, 2, 0);
        push(1, 1, 63, 64'd1, 1, 1, 1);
        ticks(1);
        push(0, 1, 0, 64'd1, 0, 2, 1);
        ticks(2);

        // R10: random mix of pushes, ticks and refusals
        phase = "R10 random";
        for (int i = 0; i < 4000; i++) begin
            enq_valid    = ($urandom % 3) != 0;
            enq_dest     = 3'($urandom);
            enq_bit_mode = ($urandom % 2) == 1;
            enq_bit_pos  = 6'($urandom);
            enq_value    = {$urandom, $urandom};
            enq_wide     = ($urandom % 2) == 1;
            enq_delay    = 4'($urandom);
            tick         = ($urandom % 3) != 0;
            step();
        end
        enq_valid = 1'b0;
        ticks(20);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule